// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt control of a small 8-bit processor with a 16-bit address space. It captures a maskable request and a non-maskable request, both active low. At every instruction boundary reported by the core it decides whether to divert execution. A diversion pushes the return address and the status byte onto a descending stack, turns the global enable flag off, and then reads a two-byte handler pointer from a fixed location. The result is handed to the core as a program-counter load.

The core reports instruction completion with `insn_done`, together with the address of the next instruction on `pc_in`. It marks a return-from-interrupt or a halt instruction with `rfi_req` or `halt_req` in that same cycle, and it stalls while `busy` is high. The sequencer owns a one-port byte bus to memory, with combinational read data, and keeps its own stack pointer. The active-low `ack_n` tells requesting devices that a service is in progress. It stays low until the outermost return completes.

States: RUN (normal execution), HALT (stopped, waiting for an interrupt), PUSH_PCH, PUSH_PCL, PUSH_ST (stack writes), VEC_LO, VEC_HI (pointer reads), POP_ST, POP_PCL, POP_PCH (stack reads). The transitions are:
- RUN to POP_ST on a boundary with `rfi_req`.
- RUN to PUSH_PCH on a boundary with an interrupt to take.
- RUN to HALT on a boundary with `halt_req`.
- HALT to PUSH_PCH when an interrupt is takeable.
- PUSH_PCH to PUSH_PCL to PUSH_ST to VEC_LO to VEC_HI to RUN.
- POP_ST to POP_PCL to POP_PCH to RUN.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset `ack_n` is 1, `busy` is 0, the enable flag `mask_o` is 0, no bus access is made and the stack pointer is 0xFF.
- R2: A maskable request held low on `irq_n` for at least one clock is remembered until it is taken. Taking it clears the memory, so once the line is high again a later boundary causes no further entry.
- R3: `mask_set` turns the enable flag on and `mask_clr` turns it off, with clear winning if both are asserted. Both act only in RUN. While the flag is off, a pending maskable request is ignored at boundaries and `busy` stays 0.
- R4: Entry writes three bytes at addresses {0x01, SP}, with SP decrementing after each byte. The order is: return address high byte, then its low byte, then the status byte. The status byte is `status_in` with bit 2 replaced by the enable flag.
- R5: The enable flag is 0 once the entry has pushed the status byte.
- R6: The handler pointer is read low byte at V and high byte at V+1, with V = 0xFFFE for a maskable entry and V = 0xFFFA for a non-maskable one. `pc_load` pulses with `pc_out` = {byte at V+1, byte at V}.
- R7: A boundary with `rfi_req` pops the status byte first, presented on `status_out` with a `status_load` pulse, and its bit 2 reloads the enable flag. It then pops the low and high return-address bytes and pulses `pc_load` with the restored address.
- R8: A non-maskable request is taken whatever the enable flag is, and it wins over a pending maskable request at the same boundary. The maskable request stays pending.
- R9: The non-maskable request responds to a high-to-low transition only, so a line held low produces exactly one entry.
- R10: A boundary with `halt_req` enters HALT, where `busy` stays 1 and boundary strobes are ignored. Only a takeable interrupt leaves HALT, and the return address it pushes is the `pc_in` given with the halt boundary. A maskable request with the flag off does not wake it.
- R11: `ack_n` goes low when an entry is accepted and returns high only when the return matching the outermost entry completes. Nested entries keep it low.
- R12: Entry takes five bus cycles and return takes three, one byte per cycle, never writing and reading in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Maskable request, active low, asynchronous |
| nmi_n | input | 1 | Non-maskable request, active low, asynchronous |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| pc_in | input | 16 | Address of the next instruction, valid with `insn_done` |
| status_in | input | 8 | Current status byte of the core |
| rfi_req | input | 1 | The completing instruction is a return-from-interrupt |
| halt_req | input | 1 | The completing instruction is a halt |
| mask_set | input | 1 | Turn the enable flag on |
| mask_clr | input | 1 | Turn the enable flag off |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_we | output | 1 | Bus write strobe |
| mem_re | output | 1 | Bus read strobe |
| mem_rdata | input | 8 | Bus read data, valid in the same cycle |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | 16 | New program counter value |
| status_load | output | 1 | Load `status_out` into the status register |
| status_out | output | 8 | Restored status byte |
| mask_o | output | 1 | Current enable flag |
| busy | output | 1 | Core must stall |
| ack_n | output | 1 | Service in progress, active low |

## Verification
The decision logic is driven with several request patterns. A short maskable pulse that is gone before the boundary separates a latched request from a sampled one. The same request with the flag off and then on shows that the flag gates only maskable entries. Simultaneous requests and a request held low separate priority from edge detection. A non-maskable entry nested inside a maskable service, and a halt woken first by a masked request and then by a non-maskable one, tell apart a correct stack depth, acknowledge span and return address from an off-by-one in the stack pointer or a stale return address.

// File: rtl/intr_pkg.sv
package intr_pkg;
    typedef enum logic [3:0] {
        ST_RUN,
        ST_HALT,
        ST_PUSH_PCH,
        ST_PUSH_PCL,
        ST_PUSH_ST,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_POP_ST,
        ST_POP_PCL,
        ST_POP_PCH
    } seq_state_t;
endpackage

// File: rtl/intr_req_capture.sv
// Two-flop synchronizer followed by a sticky pending bit.
// EDGE=1: set on a high-to-low transition; EDGE=0: set while low.
module intr_req_capture #(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic clr,
    output logic pend
);
    logic s1, s2, set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= req_n;
            s2 <= s1;
        end
    end

    generate
        if (EDGE) begin : g_edge
            logic prev;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev <= 1'b1;
                else        prev <= s2;
            end
            assign set = prev & ~s2;
        end else begin : g_level
            assign set = ~s2;
        end
    endgenerate

    // A new request arriving in the clear cycle survives.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= set | (pend & ~clr);
    end
endmodule

// File: rtl/intr_svc_depth.sv
// Counts services in progress; acknowledge is low while any is open.
module intr_svc_depth #(
    parameter int DEPTH_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic ack_n
);
    logic [DEPTH_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (inc && !dec) cnt <= cnt + 1'b1;
        else if (dec && !inc) cnt <= cnt - 1'b1;
    end

    assign ack_n = (cnt == '0);
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 8,
    parameter int                DEPTH_W    = 3,
    parameter int                MASK_BIT   = 2,
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
    parameter logic [DATA_W-1:0] SP_RESET   = 8'hFF,
    parameter logic [ADDR_W-1:0] IRQ_VEC    = 16'hFFFE,
    parameter logic [ADDR_W-1:0] NMI_VEC    = 16'hFFFA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_n,
    input  logic              nmi_n,
    input  logic              insn_done,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic              rfi_req,
    input  logic              halt_req,
    input  logic              mask_set,
    input  logic              mask_clr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_out,
    output logic              status_load,
    output logic [DATA_W-1:0] status_out,
    output logic              mask_o,
    output logic              busy,
    output logic              ack_n
);
    localparam int HI_LSB = ADDR_W - DATA_W;

    seq_state_t        state, state_nx;
    logic [DATA_W-1:0] sp, sp_up, tmp_lo;
    logic [ADDR_W-1:0] ret_pc, vec_base;
    logic              mask, is_nmi;
    logic              irq_pend, nmi_pend;
    logic              takeable, take_now, at_bound;

    assign sp_up    = sp + 1'b1;
    assign takeable = nmi_pend | (mask & irq_pend);
    assign at_bound = (state == ST_RUN) && insn_done;
    assign take_now = (at_bound && !rfi_req && takeable) ||
                      ((state == ST_HALT) && takeable);
    assign vec_base = is_nmi ? NMI_VEC : IRQ_VEC;

    intr_req_capture #(.EDGE(1'b0)) u_irq (
        .clk(clk), .rst_n(rst_n), .req_n(irq_n),
        .clr(take_now && !nmi_pend), .pend(irq_pend)
    );

    intr_req_capture #(.EDGE(1'b1)) u_nmi (
        .clk(clk), .rst_n(rst_n), .req_n(nmi_n),
        .clr(take_now && nmi_pend), .pend(nmi_pend)
    );

    intr_svc_depth #(.DEPTH_W(DEPTH_W)) u_depth (
        .clk(clk), .rst_n(rst_n),
        .inc(take_now), .dec(state == ST_POP_PCH), .ack_n(ack_n)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (insn_done) begin
                    if (rfi_req)       state_nx = ST_POP_ST;
                    else if (takeable) state_nx = ST_PUSH_PCH;
                    else if (halt_req) state_nx = ST_HALT;
                end
            end
            ST_HALT:     if (takeable) state_nx = ST_PUSH_PCH;
            ST_PUSH_PCH: state_nx = ST_PUSH_PCL;
            ST_PUSH_PCL: state_nx = ST_PUSH_ST;
            ST_PUSH_ST:  state_nx = ST_VEC_LO;
            ST_VEC_LO:   state_nx = ST_VEC_HI;
            ST_VEC_HI:   state_nx = ST_RUN;
            ST_POP_ST:   state_nx = ST_POP_PCL;
            ST_POP_PCL:  state_nx = ST_POP_PCH;
            ST_POP_PCH:  state_nx = ST_RUN;
            default:     state_nx = ST_RUN;
        endcase
    end

    // Working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp     <= SP_RESET;
            mask   <= 1'b0;
            ret_pc <= '0;
            is_nmi <= 1'b0;
            tmp_lo <= '0;
        end else begin
            if (at_bound) ret_pc <= pc_in;
            if (take_now) is_nmi <= nmi_pend;
            unique case (state)
                ST_RUN: begin
                    if (mask_clr)      mask <= 1'b0;
                    else if (mask_set) mask <= 1'b1;
                end
                ST_PUSH_PCH, ST_PUSH_PCL: sp <= sp - 1'b1;
                ST_PUSH_ST: begin
                    sp   <= sp - 1'b1;
                    mask <= 1'b0;
                end
                ST_VEC_LO: tmp_lo <= mem_rdata;
                ST_POP_ST: begin
                    sp   <= sp_up;
                    mask <= mem_rdata[MASK_BIT];
                end
                ST_POP_PCL: begin
                    sp     <= sp_up;
                    tmp_lo <= mem_rdata;
                end
                ST_POP_PCH: sp <= sp_up;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_addr    = '0;
        mem_wdata   = '0;
        mem_we      = 1'b0;
        mem_re      = 1'b0;
        pc_load     = 1'b0;
        pc_out      = {mem_rdata, tmp_lo};
        status_load = 1'b0;
        status_out  = mem_rdata;
        unique case (state)
            ST_RUN, ST_HALT: ;
            ST_PUSH_PCH: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_PAGE, sp};
                mem_wdata = ret_pc[ADDR_W-1 -: DATA_W];
            end
            ST_PUSH_PCL: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_PAGE, sp};
                mem_wdata = ret_pc[HI_LSB-1:0];
            end
            ST_PUSH_ST: begin
                mem_we              = 1'b1;
                mem_addr            = {STACK_PAGE, sp};
                mem_wdata           = status_in;
                mem_wdata[MASK_BIT] = mask;
            end
            ST_VEC_LO: begin
                mem_re   = 1'b1;
                mem_addr = vec_base;
            end
            ST_VEC_HI: begin
                mem_re   = 1'b1;
                mem_addr = vec_base + 1'b1;
                pc_load  = 1'b1;
            end
            ST_POP_ST: begin
                mem_re      = 1'b1;
                mem_addr    = {STACK_PAGE, sp_up};
                status_load = 1'b1;
            end
            ST_POP_PCL: begin
                mem_re   = 1'b1;
                mem_addr = {STACK_PAGE, sp_up};
            end
            ST_POP_PCH: begin
                mem_re   = 1'b1;
                mem_addr = {STACK_PAGE, sp_up};
                pc_load  = 1'b1;
            end
            default: ;
        endcase
    end

    assign mask_o = mask;
    assign busy   = (state != ST_RUN);
endmodule

// File: rtl/intr_entry_seq_chk.sv
module intr_entry_seq_chk
    import intr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input seq_state_t  state,
    input logic        busy,
    input logic        mask_o,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] mem_addr,
    input logic        ack_n
);
    // R12: one access kind per cycle
    p_rw_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R4: consecutive pushes walk the stack downward by one
    p_push_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));

    // R6: pointer high byte sits right above the low byte
    p_vec_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VEC_HI) |-> (mem_addr == $past(mem_addr) + 16'd1));

    // R5: the enable flag is off while the pointer is fetched
    p_mask_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VEC_LO) |-> !mask_o);

    // R11: acknowledge is low throughout an entry
    p_ack_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_PCH) |-> !ack_n);

    // R10: halted means stalled with an idle bus
    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> (busy && !mem_we && !mem_re));
endmodule

bind intr_entry_seq intr_entry_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .busy(busy), .mask_o(mask_o),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .ack_n(ack_n)
);

// File: tb/intr_entry_seq_tb.sv
`timescale 1ns/1ps
module intr_entry_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_n = 1'b1, nmi_n = 1'b1;
    logic        insn_done = 1'b0, rfi_req = 1'b0, halt_req = 1'b0;
    logic        mask_set = 1'b0, mask_clr = 1'b0;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  status_in = 8'hA1;
    logic [15:0] mem_addr, pc_out;
    logic [7:0]  mem_wdata, mem_rdata, status_out;
    logic        mem_we, mem_re, pc_load, status_load, mask_o, busy, ack_n;

    int checks = 0, failures = 0;
    int irq_ent = 0, nmi_ent = 0;
    logic [15:0] last_pc = 16'h0;
    logic [7:0]  last_st = 8'h0;
    logic [7:0]  stk [256];

    always #2.5 clk = ~clk;

    intr_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
        .insn_done(insn_done), .pc_in(pc_in), .status_in(status_in),
        .rfi_req(rfi_req), .halt_req(halt_req), .mask_set(mask_set),
        .mask_clr(mask_clr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .pc_load(pc_load), .pc_out(pc_out), .status_load(status_load),
        .status_out(status_out), .mask_o(mask_o), .busy(busy), .ack_n(ack_n)
    );

    // Memory model: stack page 0x01 plus the two handler pointers.
    always_comb begin
        if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
        else begin
            case (mem_addr)
                16'hFFFA: mem_rdata = 8'h34;
                16'hFFFB: mem_rdata = 8'h12;
                16'hFFFE: mem_rdata = 8'h78;
                16'hFFFF: mem_rdata = 8'h56;
                default:  mem_rdata = 8'h00;
            endcase
        end
    end

    always @(posedge clk)
        if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

    always @(negedge clk) begin
        if (pc_load) last_pc <= pc_out;
        if (status_load) last_st <= status_out;
        if (mem_re && mem_addr == 16'hFFFE) irq_ent <= irq_ent + 1;
        if (mem_re && mem_addr == 16'hFFFA) nmi_ent <= nmi_ent + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bound(input logic [15:0] pc, input logic rfi, input logic hlt);
        @(negedge clk);
        insn_done = 1'b1; pc_in = pc; rfi_req = rfi; halt_req = hlt;
        @(negedge clk);
        insn_done = 1'b0; rfi_req = 1'b0; halt_req = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 30) begin @(negedge clk); n++; end
        @(negedge clk);
        chk(req, busy, 1'b0);
    endtask

    task automatic pulse_irq();
        @(negedge clk); irq_n = 1'b0;
        repeat (2) @(negedge clk); irq_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_nmi();
        @(negedge clk); nmi_n = 1'b0;
        repeat (2) @(negedge clk); nmi_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic mask_op(input logic s, input logic c);
        @(negedge clk); mask_set = s; mask_clr = c;
        @(negedge clk); mask_set = 1'b0; mask_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ack_n", ack_n, 1'b1);
        chk("R1 busy", busy, 1'b0);
        chk("R1 mask", mask_o, 1'b0);
        chk("R1 bus idle", {mem_we, mem_re}, 2'b00);
    endtask

    task automatic t_masked_then_taken();
        pulse_irq();
        bound(16'h0100, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk("R3 masked irq no stall", busy, 1'b0);
        chk("R3 masked irq no entry", irq_ent, 0);
        mask_op(1'b1, 1'b1);
        chk("R3 clear wins", mask_o, 1'b0);
        mask_op(1'b1, 1'b0);
        chk("R3 set", mask_o, 1'b1);
        bound(16'h0200, 1'b0, 1'b0);
        chk("R11 ack low at entry", ack_n, 1'b0);
        wait_idle("R12 entry ends");
        chk("R2 latched pulse taken", irq_ent, 1);
        chk("R4 push pc high", stk[8'hFF], 8'h02);
        chk("R4 push pc low", stk[8'hFE], 8'h00);
        chk("R4 push status", stk[8'hFD], 8'hA5);
        chk("R5 mask off", mask_o, 1'b0);
        chk("R6 irq handler", last_pc, 16'h5678);
        chk("R11 ack held", ack_n, 1'b0);
    endtask

    task automatic t_return();
        bound(16'h5700, 1'b1, 1'b0);
        wait_idle("R12 return ends");
        chk("R7 status restored", last_st, 8'hA5);
        chk("R7 pc restored", last_pc, 16'h0200);
        chk("R7 mask restored", mask_o, 1'b1);
        chk("R11 ack released", ack_n, 1'b1);
        bound(16'h0202, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk("R2 latch cleared on take", irq_ent, 1);
    endtask

    task automatic t_nmi_edge();
        mask_op(1'b0, 1'b1);
        @(negedge clk); nmi_n = 1'b0;
        repeat (4) @(negedge clk);
        bound(16'h0300, 1'b0, 1'b0);
        wait_idle("R8 nmi entry ends");
        chk("R8 nmi taken while masked", nmi_ent, 1);
        chk("R6 nmi handler", last_pc, 16'h1234);
        chk("R4 status with mask off", stk[8'hFD], 8'hA1);
        bound(16'h1240, 1'b1, 1'b0);
        wait_idle("R7 nmi return ends");
        chk("R7 nmi return pc", last_pc, 16'h0300);
        bound(16'h0302, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk("R9 held low one entry", nmi_ent, 1);
        nmi_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_priority();
        mask_op(1'b1, 1'b0);
        @(negedge clk); irq_n = 1'b0; nmi_n = 1'b0;
        repeat (2) @(negedge clk); irq_n = 1'b1; nmi_n = 1'b1;
        repeat (4) @(negedge clk);
        bound(16'h0400, 1'b0, 1'b0);
        wait_idle("R8 prio entry ends");
        chk("R8 nmi wins", nmi_ent, 2);
        chk("R8 irq waits", irq_ent, 1);
        chk("R8 nmi handler", last_pc, 16'h1234);
        bound(16'h1240, 1'b1, 1'b0);
        wait_idle("R7 prio return ends");
        chk("R7 mask back on", mask_o, 1'b1);
        bound(16'h0410, 1'b0, 1'b0);
        wait_idle("R8 deferred irq ends");
        chk("R8 deferred irq taken", irq_ent, 2);
        chk("R4 deferred push low", stk[8'hFE], 8'h10);
        bound(16'h5700, 1'b1, 1'b0);
        wait_idle("R7 deferred return ends");
        chk("R7 deferred return pc", last_pc, 16'h0410);
    endtask

    task automatic t_nested();
        pulse_irq();
        bound(16'h0500, 1'b0, 1'b0);
        wait_idle("R11 outer entry ends");
        pulse_nmi();
        bound(16'h5680, 1'b0, 1'b0);
        wait_idle("R11 inner entry ends");
        chk("R4 nested push high", stk[8'hFC], 8'h56);
        chk("R4 nested push low", stk[8'hFB], 8'h80);
        bound(16'h1240, 1'b1, 1'b0);
        wait_idle("R11 inner return ends");
        chk("R7 inner return pc", last_pc, 16'h5680);
        chk("R11 ack still low", ack_n, 1'b0);
        bound(16'h5700, 1'b1, 1'b0);
        wait_idle("R11 outer return ends");
        chk("R7 outer return pc", last_pc, 16'h0500);
        chk("R11 ack high after outer", ack_n, 1'b1);
    endtask

    task automatic t_halt();
        int e0;
        mask_op(1'b0, 1'b1);
        bound(16'h0600, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        chk("R10 halted", busy, 1'b1);
        e0 = nmi_ent + irq_ent;
        bound(16'h0700, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk("R10 boundary ignored", {24'h0, busy, ack_n}, 32'h3);
        pulse_irq();
        chk("R10 masked irq no wake", busy, 1'b1);
        chk("R10 no entry", nmi_ent + irq_ent, e0);
        pulse_nmi();
        wait_idle("R10 wake entry ends");
        chk("R10 nmi wakes", nmi_ent, 4);
        chk("R10 return addr high", stk[8'hFF], 8'h06);
        chk("R10 return addr low", stk[8'hFE], 8'h00);
        bound(16'h1240, 1'b1, 1'b0);
        wait_idle("R10 return ends");
        chk("R10 resume pc", last_pc, 16'h0600);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked_then_taken();
        t_return();
        t_nmi_edge();
        t_priority();
        t_nested();
        t_halt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule